// File: doc/BRIEF.md
# Power-on reset delay sequencer

This block keeps the rest of the chip in reset after the supply comes up. Once an analog detector reports that the supply is above its threshold, the block counts a configurable number of cycles of a slow free-running oscillator. It then moves that completion into the system clock domain and counts a fixed number of system clock cycles. Only after both counts does it release reset. The slow-oscillator length comes from a 2-bit clock-select setting and a brown-out enable bit. Both configuration inputs are active-low: 0 means programmed (enabled) and 1 means unprogrammed.

When the supply flag falls, reset is asserted at once through a combinational path, and all count state is cleared. A wake-from-power-down request, given while reset is released, runs a short sequence that uses only the system-clock count. A single-cycle release pulse marks every release, so the total delay of each setting can be measured.

Top module: `por_delay_seq`

## Requirements
- R1: `rst_out` is 1 whenever `supply_ok` is 0. It rises in the same time step that `supply_ok` falls, with no clock edge needed.
- R2: With `clk_sel` = 2'b00, the slow count is LONG_CYC slow-oscillator cycles.
- R3: With `clk_sel` = 2'b01, the slow count is LONG_CYC slow-oscillator cycles.
- R4: With `clk_sel` = 2'b10, the slow count is MID_CYC slow-oscillator cycles, for either value of `bod_n`.
- R5: With `clk_sel` = 2'b11 and `bod_n` = 1 (brown-out detection off), the slow count is SHORT_CYC slow-oscillator cycles.
- R6: With `clk_sel` = 2'b11 and `bod_n` = 0 (brown-out detection on), the slow count is SHORT_BOD_CYC slow-oscillator cycles.
- R7: The first rising `osc_clk` edge after `supply_ok` rises captures the configuration. The count then ends on the N-th `osc_clk` edge after that capture edge. `rst_out` falls on the 20th `sys_clk` rising edge after that edge: 2 synchronizer stages plus SYS_CYC = 18 counting edges.
- R8: A change to `clk_sel` or `bod_n` after the capture edge has no effect on the sequence in progress.
- R9: A drop of `supply_ok` during a count discards that count. The next rise starts a fresh full sequence.
- R10: A `wake_req` sampled high on a `sys_clk` edge while `rst_out` is 0 raises `rst_out` after that edge. `rst_out` then falls on the 18th following `sys_clk` edge, with no slow-oscillator count.
- R11: `wake_req` during a power-up sequence is ignored, and the release timing stays unchanged.
- R12: `rel_pulse` is 1 for exactly one `sys_clk` cycle, starting at the edge where `rst_out` falls, and is 0 at all other times, including reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System clock |
| osc_clk | input | 1 | Slow free-running oscillator clock |
| supply_ok | input | 1 | Supply above threshold; 0 clears all state asynchronously |
| clk_sel | input | 2 | Start-up length select, captured at sequence start |
| bod_n | input | 1 | Brown-out enable, 0 = enabled |
| wake_req | input | 1 | Wake-from-power-down request, synchronous to sys_clk |
| rst_out | output | 1 | Active-high reset to the chip |
| rel_pulse | output | 1 | One-cycle pulse on reset release |

## Verification
The bench builds the block with LONG_CYC = 64 and MID_CYC = 16 in place of the full-length defaults. SHORT_CYC = 8, SHORT_BOD_CYC = 32 and SYS_CYC = 18 keep their real values. This puts every clock-select row, including the two long ones, within a few thousand cycles of each other. It also keeps the five lengths distinct, so a swapped table entry changes the measured release edge. The slow clock runs at a quarter of the system rate, with its rising edges on system falling edges. This lets the release edge be predicted exactly, which exercises the synchronizer depth and the 18-cycle count.

// File: rtl/por_pkg.sv
// Package: shared encodings for the power-on reset delay sequencer.
// Assumes: clock-select codes are the raw 2-bit configuration values.
package por_pkg;

    // Clock-select codes; the length each selects is fixed by the block's behaviour
    localparam logic [1:0] SEL_LONG_A = 2'b00;
    localparam logic [1:0] SEL_LONG_B = 2'b01;
    localparam logic [1:0] SEL_MID    = 2'b10;
    localparam logic [1:0] SEL_SHORT  = 2'b11;

    // System-domain release states
    typedef enum logic [1:0] {
        ST_SEQ  = 2'd0,   // power-up: wait for slow count, then system count
        ST_RUN  = 2'd1,   // reset released
        ST_WAKE = 2'd2    // wake: system count only
    } rel_state_t;

endpackage

// File: rtl/por_slow_timer.sv
// Module: por_slow_timer
// Counts the real-time part of the start-up delay on the slow oscillator.
// On the first osc_clk edge after supply_ok rises it captures the length
// selected by clk_sel/bod_n, then raises done on the N-th following edge.
// Assumes: supply_ok low is the reset (asynchronous clear, active low);
// configuration inputs are quasi-static around the capture edge.
module por_slow_timer
    import por_pkg::*;
#(
    parameter int unsigned LONG_CYC      = 65536,
    parameter int unsigned MID_CYC       = 4096,
    parameter int unsigned SHORT_CYC     = 8,
    parameter int unsigned SHORT_BOD_CYC = 32
) (
    input  logic       osc_clk,
    input  logic       supply_ok,
    input  logic [1:0] clk_sel,
    input  logic       bod_n,
    output logic       done
);

    localparam int unsigned CNT_W = $clog2(LONG_CYC + MID_CYC + SHORT_CYC + SHORT_BOD_CYC + 1);

    logic             armed;
    logic [CNT_W-1:0] limit_q;
    logic [CNT_W-1:0] limit_d;
    logic [CNT_W-1:0] cnt_q;

    // Decode the configured length (bod_n = 0 means brown-out enabled)
    always_comb begin
        unique case (clk_sel)
            SEL_LONG_A, SEL_LONG_B: limit_d = CNT_W'(LONG_CYC);
            SEL_MID:                limit_d = CNT_W'(MID_CYC);
            default:                limit_d = bod_n ? CNT_W'(SHORT_CYC) : CNT_W'(SHORT_BOD_CYC);
        endcase
    end

    // Capture length once, then count slow edges up to it
    always_ff @(posedge osc_clk or negedge supply_ok) begin
        if (!supply_ok) begin
            armed   <= 1'b0;
            limit_q <= '0;
            cnt_q   <= '0;
            done    <= 1'b0;
        end else if (!armed) begin
            armed   <= 1'b1;
            limit_q <= limit_d;
            cnt_q   <= '0;
        end else if (!done) begin
            cnt_q <= cnt_q + CNT_W'(1);
            if (cnt_q == limit_q - CNT_W'(1)) begin
                done <= 1'b1;
            end
        end
    end

    // R8: captured length holds for the rest of the sequence
    p_limit_stable_r8: assert property (@(posedge osc_clk) disable iff (!supply_ok)
        armed |=> $stable(limit_q));

    // R2: the counter never runs past the captured length
    p_cnt_in_limit_r2: assert property (@(posedge osc_clk) disable iff (!supply_ok)
        cnt_q <= limit_q);

    // R7: completion is never withdrawn within a sequence
    p_done_sticky_r7: assert property (@(posedge osc_clk) disable iff (!supply_ok)
        done |=> done);

endmodule

// File: rtl/por_sync2.sv
// Module: por_sync2
// Multi-flop level synchronizer carrying the slow-count completion into
// the system clock domain.
// Assumes: STAGES >= 2; the input is a level that only rises within a sequence.
module por_sync2 #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic clr_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] pipe;

    // Shift the input level through the synchronizer chain
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[STAGES-2:0], d};
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/por_release_fsm.sv
// Module: por_release_fsm
// System-domain part of the delay. After power-up it waits for the
// synchronized slow completion and then counts SYS_CYC edges. After a wake
// request it counts SYS_CYC edges directly. It drives the reset hold and the
// release pulse.
// Assumes: supply_ok low is the reset (asynchronous clear, active low);
// wake_req is synchronous to sys_clk; SYS_CYC >= 2.
module por_release_fsm
    import por_pkg::*;
#(
    parameter int unsigned SYS_CYC = 18
) (
    input  logic sys_clk,
    input  logic supply_ok,
    input  logic slow_done_s,
    input  logic wake_req,
    output logic hold,
    output logic rel_pulse
);

    localparam int unsigned CW   = $clog2(SYS_CYC);
    localparam logic [CW-1:0] LAST = CW'(SYS_CYC - 1);

    rel_state_t    state;
    logic [CW-1:0] cnt;
    logic          counting;

    // Count enable: wake counts at once, power-up waits for the slow part
    assign counting = (state == ST_WAKE) || (state == ST_SEQ && slow_done_s);

    // Sequence states, system count, hold and release pulse
    always_ff @(posedge sys_clk or negedge supply_ok) begin
        if (!supply_ok) begin
            state     <= ST_SEQ;
            cnt       <= '0;
            hold      <= 1'b1;
            rel_pulse <= 1'b0;
        end else begin
            rel_pulse <= 1'b0;
            case (state)
                ST_SEQ, ST_WAKE: begin
                    if (counting) begin
                        if (cnt == LAST) begin
                            hold      <= 1'b0;
                            rel_pulse <= 1'b1;
                            state     <= ST_RUN;
                            cnt       <= '0;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                end
                ST_RUN: begin
                    if (wake_req) begin
                        hold  <= 1'b1;
                        state <= ST_WAKE;
                        cnt   <= '0;
                    end
                end
                default: state <= ST_SEQ;
            endcase
        end
    end

    // R7: system count stays in range
    p_cnt_range_r7: assert property (@(posedge sys_clk) disable iff (!supply_ok)
        cnt <= LAST);

    // R7: no release while power-up still waits on the slow part
    p_wait_slow_r7: assert property (@(posedge sys_clk) disable iff (!supply_ok)
        (state == ST_SEQ && !slow_done_s) |=> hold);

    // R12: release pulse lasts a single cycle
    p_pulse_single_r12: assert property (@(posedge sys_clk) disable iff (!supply_ok)
        rel_pulse |=> !rel_pulse);

endmodule

// File: rtl/por_delay_seq.sv
// Module: por_delay_seq (top)
// Power-on reset delay sequencer: slow-oscillator count, two-flop crossing,
// then a fixed system-clock count before reset is released. The supply flag
// forces reset combinationally and clears every register asynchronously.
// Assumes: supply_ok is glitch-filtered by the analog detector.
module por_delay_seq #(
    parameter int unsigned LONG_CYC      = 65536,
    parameter int unsigned MID_CYC       = 4096,
    parameter int unsigned SHORT_CYC     = 8,
    parameter int unsigned SHORT_BOD_CYC = 32,
    parameter int unsigned SYS_CYC       = 18,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic       sys_clk,
    input  logic       osc_clk,
    input  logic       supply_ok,
    input  logic [1:0] clk_sel,
    input  logic       bod_n,
    input  logic       wake_req,
    output logic       rst_out,
    output logic       rel_pulse
);

    logic slow_done;
    logic slow_done_s;
    logic hold;

    por_slow_timer #(
        .LONG_CYC      (LONG_CYC),
        .MID_CYC       (MID_CYC),
        .SHORT_CYC     (SHORT_CYC),
        .SHORT_BOD_CYC (SHORT_BOD_CYC)
    ) u_slow (
        .osc_clk   (osc_clk),
        .supply_ok (supply_ok),
        .clk_sel   (clk_sel),
        .bod_n     (bod_n),
        .done      (slow_done)
    );

    por_sync2 #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (sys_clk),
        .clr_n (supply_ok),
        .d     (slow_done),
        .q     (slow_done_s)
    );

    por_release_fsm #(
        .SYS_CYC (SYS_CYC)
    ) u_fsm (
        .sys_clk     (sys_clk),
        .supply_ok   (supply_ok),
        .slow_done_s (slow_done_s),
        .wake_req    (wake_req),
        .hold        (hold),
        .rel_pulse   (rel_pulse)
    );

    // Reset is forced at once by a low supply, otherwise follows the hold
    assign rst_out = hold | ~supply_ok;

    // R10: a wake request while released brings reset back
    p_wake_reasserts_r10: assert property (@(posedge sys_clk) disable iff (!supply_ok)
        (!rst_out && wake_req) |=> rst_out);

    // R12: the release pulse only appears with reset released
    p_pulse_released_r12: assert property (@(posedge sys_clk) disable iff (!supply_ok)
        rel_pulse |-> !rst_out);

endmodule

// File: tb/sim_por_delay_seq.sv
module sim_por_delay_seq;

    localparam int SYS_PERIOD = 10;
    localparam int LONG_N     = 64;
    localparam int MID_N      = 16;
    localparam int SHORT_N    = 8;
    localparam int BOD_N      = 32;

    logic       sys_clk = 1'b0;
    logic       osc_clk = 1'b0;
    logic       supply_ok;
    logic [1:0] clk_sel;
    logic       bod_n;
    logic       wake_req;
    logic       rst_out;
    logic       rel_pulse;

    int checks = 0;
    int errors = 0;

    por_delay_seq #(
        .LONG_CYC      (LONG_N),
        .MID_CYC       (MID_N),
        .SHORT_CYC     (SHORT_N),
        .SHORT_BOD_CYC (BOD_N),
        .SYS_CYC       (18),
        .SYNC_STAGES   (2)
    ) u0 (
        .sys_clk   (sys_clk),
        .osc_clk   (osc_clk),
        .supply_ok (supply_ok),
        .clk_sel   (clk_sel),
        .bod_n     (bod_n),
        .wake_req  (wake_req),
        .rst_out   (rst_out),
        .rel_pulse (rel_pulse)
    );

    // System clock; slow clock at quarter rate with rising edges on system falling edges
    always #(SYS_PERIOD/2) sys_clk = ~sys_clk;
    always #(SYS_PERIOD*2) osc_clk = ~osc_clk;

    task automatic check(string req, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Drop the supply and check reset rises with no clock edge (R1)
    task automatic power_down();
        @(posedge sys_clk);
        #1 supply_ok = 1'b0;
        #1 check("R1", rst_out, 1'b1, "reset on supply drop");
        repeat (3) @(posedge sys_clk);
        #1 check("R1", rst_out, 1'b1, "reset while supply low");
    endtask

    // Full power-up: optional config change after capture, optional wake mid-count
    task automatic run_seq(logic [1:0] sel, logic bod, int n, bit chg,
                           logic [1:0] new_sel, logic new_bod, bit wake_mid, string req);
        clk_sel = sel;
        bod_n   = bod;
        @(posedge sys_clk);
        #1 supply_ok = 1'b1;
        @(posedge osc_clk);                 // capture edge
        #1;
        if (chg) begin
            clk_sel = new_sel;
            bod_n   = new_bod;
        end
        repeat (n - 1) @(posedge osc_clk);
        #1 check(req, rst_out, 1'b1, "held before last slow edge");
        @(posedge osc_clk);                 // slow count completes
        for (int i = 0; i < 19; i++) begin
            @(posedge sys_clk);
            #1 check(req, rst_out, 1'b1, "held during system count");
            wake_req = (wake_mid && i == 4) ? 1'b1 : 1'b0;
        end
        @(posedge sys_clk);
        #1 check(req, rst_out, 1'b0, "released on 20th system edge (R7)");
        check("R12", rel_pulse, 1'b1, "pulse at release");
        @(posedge sys_clk);
        #1 check("R12", rel_pulse, 1'b0, "pulse one cycle");
        check(req, rst_out, 1'b0, "stays released");
    endtask

    // R10: wake from power-down uses only the system count
    task automatic wake_test();
        @(posedge sys_clk);
        #1 wake_req = 1'b1;
        @(posedge sys_clk);                 // wake sampled here
        #1 wake_req = 1'b0;
        check("R10", rst_out, 1'b1, "reset after wake");
        repeat (17) @(posedge sys_clk);
        #1 check("R10", rst_out, 1'b1, "held at 17th wake edge");
        @(posedge sys_clk);
        #1 check("R10", rst_out, 1'b0, "released at 18th wake edge");
        check("R12", rel_pulse, 1'b1, "pulse after wake");
        @(posedge sys_clk);
        #1 check("R12", rel_pulse, 1'b0, "wake pulse one cycle");
    endtask

    // R9: abort a long count, then a fresh short sequence must run in full
    task automatic abort_test();
        clk_sel = 2'b11;
        bod_n   = 1'b0;
        @(posedge sys_clk);
        #1 supply_ok = 1'b1;
        repeat (21) @(posedge osc_clk);
        #1 check("R9", rst_out, 1'b1, "held mid-count");
        power_down();
        run_seq(2'b11, 1'b1, SHORT_N, 1'b0, 2'b00, 1'b1, 1'b0, "R9");
    endtask

    initial begin
        supply_ok = 1'b0;
        clk_sel   = 2'b00;
        bod_n     = 1'b1;
        wake_req  = 1'b0;
        repeat (3) @(posedge sys_clk);
        #1 check("R1", rst_out, 1'b1, "reset state");
        check("R12", rel_pulse, 1'b0, "no pulse in reset");

        run_seq(2'b00, 1'b1, LONG_N, 1'b0, 2'b00, 1'b1, 1'b0, "R2");
        power_down();
        run_seq(2'b01, 1'b1, LONG_N, 1'b0, 2'b00, 1'b1, 1'b0, "R3");
        wake_test();
        power_down();
        run_seq(2'b10, 1'b0, MID_N, 1'b0, 2'b00, 1'b1, 1'b0, "R4");
        power_down();
        run_seq(2'b11, 1'b1, SHORT_N, 1'b0, 2'b00, 1'b1, 1'b0, "R5");
        power_down();
        run_seq(2'b11, 1'b0, BOD_N, 1'b0, 2'b00, 1'b1, 1'b0, "R6");
        power_down();
        run_seq(2'b10, 1'b1, MID_N, 1'b1, 2'b11, 1'b1, 1'b0, "R8");
        power_down();
        abort_test();
        power_down();
        run_seq(2'b11, 1'b1, SHORT_N, 1'b0, 2'b00, 1'b1, 1'b1, "R11");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(SYS_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule